// File: doc/BRIEF.md
# SDRAM Single-Word Access Sequencer

This block sits between a simple host port and one SDRAM device. Each host request moves one 32-bit word. The block opens the row, waits the row-to-column delay and issues a column read or write with auto-precharge. It then waits out write recovery and precharge before it can start the next access. Read data is taken from the SDRAM data bus a fixed CAS latency after the read command and handed back to the host with a one-cycle valid pulse.

A separate refresh timer pulses a refresh input. The block remembers the pulse and issues an auto-refresh command as soon as it is idle. If an access is in progress, the refresh waits until that access and its precharge have finished. After a refresh it keeps the command bus quiet for the refresh recovery time. No row is ever left open, so every access costs the same fixed sequence of cycles.

The host raises `req` together with `we`, `addr` and `wdata`, and holds them until it sees `ready` high at a clock edge. Only one access can be in progress at a time.

Top module: `sdram_seq`

## Requirements
- R1: Command encoding on {sdCsN, sdRasN, sdCasN, sdWeN} is: NOP 0111, activate 0011, read 0101, write 0100, auto-refresh 0001. No other value is ever driven. During and after reset the outputs are: NOP on the command bus, sdDqOe low, sdDqm all ones, rvalid low, and ready high.
- R2: Between an activate and the read or write that follows it there are exactly 2 NOP cycles.
- R3: A read or write command drives sdA[10] high (auto-precharge), the column on sdA[8:0], and zeros on the other sdA bits. It drives the same bank that the preceding activate drove.
- R4: For a read, sdDqIn is sampled in the second cycle after the cycle holding the read command. That word appears on rdata with rvalid high for exactly one cycle, three cycles after the read command cycle.
- R5: sdDqOe is high only in the cycle holding a write command, and it is always high in that cycle. In that cycle sdDqOut equals the host's wdata. sdDqm is all zeros in read and write command cycles and all ones in every other cycle.
- R6: After a write, at least 3 NOP cycles (2 for write recovery, 1 for precharge) pass before the next command.
- R7: After a read, at least 3 NOP cycles (2 for CAS latency, 1 for precharge) pass before the next command.
- R8: After an auto-refresh, at least 5 NOP cycles pass before the next command.
- R9: A refresh pulse that arrives during an access, or in the same cycle as an accepted request, is held. It produces exactly one auto-refresh, issued after that access's read or write command and before the next activate. No auto-refresh is issued without a pulse.
- R10: A request is accepted in a cycle where req and ready are both high. ready is low in the following cycle and stays low until the access is over. Each accepted request yields exactly one activate and exactly one read or write.
- R11: The host address splits as column addr[8:0], row addr[21:9] and bank addr[23:22]. An activate drives the row on sdA and the bank on sdBa.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 24 | Host word address {bank, row, column} |
| wdata | input | 32 | Write data |
| ready | output | 1 | Block can accept a request this cycle |
| rvalid | output | 1 | Read data valid pulse |
| rdata | output | 32 | Read data |
| refReq | input | 1 | Refresh request pulse from the refresh timer |
| sdCsN | output | 1 | SDRAM chip select, active low |
| sdRasN | output | 1 | SDRAM row strobe, active low |
| sdCasN | output | 1 | SDRAM column strobe, active low |
| sdWeN | output | 1 | SDRAM write enable, active low |
| sdBa | output | 2 | SDRAM bank select |
| sdA | output | 13 | SDRAM address lines |
| sdDqOut | output | 32 | Data driven toward the SDRAM |
| sdDqIn | input | 32 | Data returned by the SDRAM |
| sdDqOe | output | 1 | Output enable for sdDqOut |
| sdDqm | output | 4 | Byte data masks |

## Verification
The assertions check the following on every cycle:
- only legal command codes appear on the bus;
- the activate-to-column spacing is exact;
- auto-precharge is requested on every column command;
- the data output enable and masks line up with write and read commands;
- write, read and refresh recovery gaps are respected;
- rvalid arrives a fixed distance after a read;
- ready drops after an acceptance.

Only the bench scenarios can show that data reaches the right bank, row and column, and that read words come back intact. They also show that a refresh raised mid-access is postponed and served exactly once, and that each request produces exactly one activate and one column command.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_REF   = 4'b0001
  } sdCmd_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accept;
    logic activate;
    logic readCmd;
    logic writeCmd;
    logic refresh;
    logic capture;
  } seqStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdseq_pkg::*;
#(
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_RP    = 1,
  parameter int T_WR    = 2,
  parameter int T_RFC   = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       we,
  input  logic       refReq,
  output logic       ready,
  output seqStrobe_t strobe
);

  localparam int MAX_WAIT = maxOf(maxOf(maxOf(T_RCD, CAS_LAT + 1), maxOf(T_RP, T_WR)), T_RFC);
  localparam int CNT_W    = $clog2(MAX_WAIT + 2);

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_RCD, S_RW, S_CAS, S_WR, S_RP, S_REF, S_RFC
  } state_t;

  state_t           state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             isWrite;
  logic             refPend;
  logic             lastTick;
  logic             refTake;

  assign lastTick = (cnt == CNT_W'(1));
  assign refTake  = (state == S_IDLE) && refPend;
  assign ready    = (state == S_IDLE) && !refPend;

  always_comb begin
    stateNext = state;
    cntNext   = (cnt != '0) ? cnt - CNT_W'(1) : cnt;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (refPend) begin
          stateNext = S_REF;
        end else if (req) begin
          strobe.accept = 1'b1;
          stateNext     = S_ACT;
        end
      end
      S_ACT: begin
        strobe.activate = 1'b1;
        stateNext       = S_RCD;
        cntNext         = CNT_W'(T_RCD);
      end
      S_RCD: begin
        if (lastTick) stateNext = S_RW;
      end
      S_RW: begin
        if (isWrite) begin
          strobe.writeCmd = 1'b1;
          stateNext       = S_WR;
          cntNext         = CNT_W'(T_WR);
        end else begin
          strobe.readCmd = 1'b1;
          stateNext      = S_CAS;
          cntNext        = CNT_W'(CAS_LAT + 1);
        end
      end
      S_CAS: begin
        if (lastTick) begin
          strobe.capture = 1'b1;
          stateNext      = S_RP;
          cntNext        = CNT_W'(T_RP);
        end
      end
      S_WR: begin
        if (lastTick) begin
          stateNext = S_RP;
          cntNext   = CNT_W'(T_RP);
        end
      end
      S_RP: begin
        if (lastTick) stateNext = S_IDLE;
      end
      S_REF: begin
        strobe.refresh = 1'b1;
        stateNext      = S_RFC;
        cntNext        = CNT_W'(T_RFC);
      end
      S_RFC: begin
        if (lastTick) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
      refPend <= 1'b0;
    end else begin
      state   <= stateNext;
      cnt     <= cntNext;
      refPend <= refReq | (refPend & ~refTake);
      if (strobe.accept) isWrite <= we;
    end
  end

endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdseq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int DATA_W = 32,
  parameter int AP_BIT = 10
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  seqStrobe_t                       strobe,
  input  logic [BANK_W+ROW_W+COL_W-1:0]    addr,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [DATA_W-1:0]                sdDqIn,
  output logic                             rvalid,
  output logic [DATA_W-1:0]                rdata,
  output logic                             sdCsN,
  output logic                             sdRasN,
  output logic                             sdCasN,
  output logic                             sdWeN,
  output logic [BANK_W-1:0]                sdBa,
  output logic [ROW_W-1:0]                 sdA,
  output logic [DATA_W-1:0]                sdDqOut,
  output logic                             sdDqOe,
  output logic [DATA_W/8-1:0]              sdDqm
);

  localparam int ADDR_W = BANK_W + ROW_W + COL_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [COL_W-1:0]  colF;
  logic [ROW_W-1:0]  rowF;
  logic [BANK_W-1:0] bankF;
  logic [ROW_W-1:0]  colWord;
  sdCmd_t            cmdQ;

  assign colF  = addrQ[COL_W-1:0];
  assign rowF  = addrQ[COL_W +: ROW_W];
  assign bankF = addrQ[COL_W+ROW_W +: BANK_W];

  always_comb begin
    colWord              = '0;
    colWord[COL_W-1:0]   = colF;
    colWord[AP_BIT]      = 1'b1;
  end

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      cmdQ    <= CMD_NOP;
      sdBa    <= '0;
      sdA     <= '0;
      sdDqOut <= '0;
      sdDqOe  <= 1'b0;
      sdDqm   <= '1;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      cmdQ   <= CMD_NOP;
      sdDqOe <= 1'b0;
      sdDqm  <= '1;
      rvalid <= strobe.capture;
      if (strobe.capture) rdata <= sdDqIn;
      if (strobe.accept) begin
        addrQ  <= addr;
        wdataQ <= wdata;
      end
      if (strobe.activate) begin
        cmdQ <= CMD_ACT;
        sdBa <= bankF;
        sdA  <= rowF;
      end
      if (strobe.readCmd) begin
        cmdQ  <= CMD_READ;
        sdBa  <= bankF;
        sdA   <= colWord;
        sdDqm <= '0;
      end
      if (strobe.writeCmd) begin
        cmdQ    <= CMD_WRITE;
        sdBa    <= bankF;
        sdA     <= colWord;
        sdDqOut <= wdataQ;
        sdDqOe  <= 1'b1;
        sdDqm   <= '0;
      end
      if (strobe.refresh) cmdQ <= CMD_REF;
    end
  end

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdseq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 32,
  parameter int AP_BIT  = 10,
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_RP    = 1,
  parameter int T_WR    = 2,
  parameter int T_RFC   = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          req,
  input  logic                          we,
  input  logic [BANK_W+ROW_W+COL_W-1:0] addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic                          ready,
  output logic                          rvalid,
  output logic [DATA_W-1:0]             rdata,
  input  logic                          refReq,
  output logic                          sdCsN,
  output logic                          sdRasN,
  output logic                          sdCasN,
  output logic                          sdWeN,
  output logic [BANK_W-1:0]             sdBa,
  output logic [ROW_W-1:0]              sdA,
  output logic [DATA_W-1:0]             sdDqOut,
  input  logic [DATA_W-1:0]             sdDqIn,
  output logic                          sdDqOe,
  output logic [DATA_W/8-1:0]           sdDqm
);

  seqStrobe_t strobe;

  sdram_seq_ctrl #(
    .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_RP(T_RP), .T_WR(T_WR), .T_RFC(T_RFC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .refReq(refReq),
    .ready(ready), .strobe(strobe)
  );

  sdram_seq_dp #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .AP_BIT(AP_BIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wdata(wdata),
    .sdDqIn(sdDqIn), .rvalid(rvalid), .rdata(rdata),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdA(sdA), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .sdDqm(sdDqm)
  );

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdseq_pkg::*;
#(
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_RP    = 1,
  parameter int T_WR    = 2,
  parameter int T_RFC   = 5,
  parameter int DM_W    = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            req,
  input logic            ready,
  input logic            rvalid,
  input logic            sdCsN,
  input logic            sdRasN,
  input logic            sdCasN,
  input logic            sdWeN,
  input logic            apBit,
  input logic            sdDqOe,
  input logic [DM_W-1:0] sdDqm
);

  logic [3:0] cmd;
  logic [3:0] lastCmd;
  logic [7:0] gap;
  logic [7:0] rdAge;
  logic       isRw;
  logic       isCmd;

  assign cmd   = {sdCsN, sdRasN, sdCasN, sdWeN};
  assign isRw  = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign isCmd = (cmd != CMD_NOP);

  // cycles since the previous command, cycles since the previous read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCmd <= CMD_NOP;
      gap     <= 8'hFF;
      rdAge   <= 8'hFF;
    end else begin
      if (isCmd) begin
        lastCmd <= cmd;
        gap     <= 8'd1;
      end else if (gap != 8'hFF) begin
        gap <= gap + 8'd1;
      end
      if (cmd == CMD_READ) rdAge <= 8'd1;
      else if (rdAge != 8'hFF) rdAge <= rdAge + 8'd1;
    end
  end

  p_legal_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_NOP) || (cmd == CMD_ACT) || (cmd == CMD_READ) ||
    (cmd == CMD_WRITE) || (cmd == CMD_REF));

  p_act_to_col_r2: assert property (@(posedge clk) disable iff (!rstN)
    isRw |-> (lastCmd == CMD_ACT) && (gap == 8'(T_RCD + 1)));

  p_auto_pre_r3: assert property (@(posedge clk) disable iff (!rstN)
    isRw |-> apBit);

  p_rvalid_lat_r4: assert property (@(posedge clk) disable iff (!rstN)
    rvalid |-> (rdAge == 8'(CAS_LAT + 1)));

  p_oe_only_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe |-> (cmd == CMD_WRITE) && (sdDqm == '0));

  p_write_drives_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_WRITE) |-> sdDqOe);

  p_wr_recovery_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && lastCmd == CMD_WRITE) |-> (gap >= 8'(T_WR + T_RP + 1)));

  p_rd_recovery_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && lastCmd == CMD_READ) |-> (gap >= 8'(CAS_LAT + T_RP + 1)));

  p_ref_recovery_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isCmd && lastCmd == CMD_REF) |-> (gap >= 8'(T_RFC + 1)));

  p_accept_drops_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    (req && ready) |=> !ready);

endmodule

bind sdram_seq sdram_seq_chk #(
  .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_RP(T_RP), .T_WR(T_WR), .T_RFC(T_RFC),
  .DM_W(DATA_W / 8)
) i_sdram_seq_chk (
  .clk(clk), .rstN(rstN), .req(req), .ready(ready), .rvalid(rvalid),
  .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
  .apBit(sdA[AP_BIT]), .sdDqOe(sdDqOe), .sdDqm(sdDqm)
);

// File: tb/test_sdram_seq.sv
module test_sdram_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TRCD = 2;
  localparam int CL   = 2;
  localparam int TRP  = 1;
  localparam int TWR  = 2;
  localparam int TRFC = 5;
  localparam int WD_LIMIT = 100000;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_REF = 4'b0001;

  logic        clk = 1'b0;
  logic        rstN;
  logic        req, we, refReq;
  logic [23:0] addr;
  logic [31:0] wdata, rdata, sdDqOut, sdDqIn;
  logic        ready, rvalid;
  logic        sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [1:0]  sdBa;
  logic [12:0] sdA;
  logic [3:0]  sdDqm;

  sdram_seq i_sdram_seq (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rvalid(rvalid), .rdata(rdata), .refReq(refReq),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdA(sdA), .sdDqOut(sdDqOut), .sdDqIn(sdDqIn),
    .sdDqOe(sdDqOe), .sdDqm(sdDqm)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nVec = 0;
  int nFail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] actual,
                     input logic [31:0] expected);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  function automatic logic [31:0] pat(input logic [23:0] a);
    return ({8'h00, a} * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // expected state from the host side
  logic [31:0] hostMem [int];
  logic [23:0] expAddr;
  logic [31:0] expData, expRdata;
  // bus-side SDRAM model
  logic [31:0] sdMem [int];
  logic [12:0] actRow [4];
  logic [3:0]  busCmd;
  logic [3:0]  lastKind = C_NOP;
  int lastCmdCyc = -100, lastReadCyc = -100, rdDueCyc = -100;
  int lastRefCyc = -100, lastActCyc = -100, lastRwCyc = -100;
  int actCount = 0, rwCount = 0, refCount = 0, rvCount = 0;
  logic [31:0] rdDueData;
  int gapNow, key;

  assign busCmd = {sdCsN, sdRasN, sdCasN, sdWeN};

  always @(negedge clk) begin
    if (rstN) begin
      gapNow = cyc - lastCmdCyc;
      if (busCmd != C_NOP) begin
        if (lastKind == C_WR)  chk(gapNow >= TWR + TRP + 1, "R6 write recovery", gapNow, TWR + TRP + 1);
        if (lastKind == C_RD)  chk(gapNow >= CL + TRP + 1, "R7 read recovery", gapNow, CL + TRP + 1);
        if (lastKind == C_REF) chk(gapNow >= TRFC + 1, "R8 refresh recovery", gapNow, TRFC + 1);
        if (busCmd == C_ACT) begin
          chk(sdBa == expAddr[23:22] && sdA == expAddr[21:9], "R11 activate bank/row",
              {17'd0, sdBa, sdA}, {17'd0, expAddr[23:22], expAddr[21:9]});
          actRow[sdBa] = sdA;
          actCount++;
          lastActCyc = cyc;
        end else if (busCmd == C_RD || busCmd == C_WR) begin
          chk(lastKind == C_ACT && gapNow == TRCD + 1, "R2 activate to column gap", gapNow, TRCD + 1);
          chk(sdA == (13'h400 | {4'd0, expAddr[8:0]}) && sdBa == expAddr[23:22],
              "R3 column address", {17'd0, sdBa, sdA}, {17'd0, expAddr[23:22], 4'd2, expAddr[8:0]});
          chk(sdDqm == 4'h0, "R5 masks on column command", {28'd0, sdDqm}, 0);
          key = int'({sdBa, actRow[sdBa], sdA[8:0]});
          rwCount++;
          lastRwCyc = cyc;
          if (busCmd == C_WR) begin
            chk(sdDqOe && sdDqOut == expData, "R5 write data", sdDqOut, expData);
            sdMem[key] = sdDqOut;
          end else begin
            chk(!sdDqOe, "R5 no drive on read", {31'd0, sdDqOe}, 0);
            lastReadCyc = cyc;
            rdDueCyc = cyc + CL;
            rdDueData = sdMem.exists(key) ? sdMem[key] : pat(key[23:0]);
          end
        end else if (busCmd == C_REF) begin
          refCount++;
          lastRefCyc = cyc;
        end else begin
          chk(1'b0, "R1 illegal command", {28'd0, busCmd}, {28'd0, C_NOP});
        end
        lastKind = busCmd;
        lastCmdCyc = cyc;
      end
      if (busCmd != C_WR)
        chk(!sdDqOe, "R5 output enable outside write", {31'd0, sdDqOe}, 0);
      if (busCmd != C_WR && busCmd != C_RD)
        chk(sdDqm == 4'hF, "R5 masks idle", {28'd0, sdDqm}, 32'hF);
      if (rvalid || cyc == lastReadCyc + CL + 1) begin
        chk(rvalid && cyc == lastReadCyc + CL + 1, "R4 rvalid timing", cyc - lastReadCyc, CL + 1);
        if (rvalid) begin
          chk(rdata == expRdata, "R4 read data", rdata, expRdata);
          rvCount++;
        end
      end
    end
    sdDqIn = (cyc == rdDueCyc) ? rdDueData : (32'hBAD00000 ^ cyc);
  end

  // refAt: 0 none, -1 refresh pulse together with the request, n>0 pulse n cycles after acceptance
  task automatic access(input bit w, input logic [23:0] ad, input logic [31:0] d, input int refAt);
    int a0, r0, v0, n;
    a0 = actCount; r0 = rwCount; v0 = rvCount;
    @(negedge clk);
    req = 1'b1; we = w; addr = ad; wdata = d;
    refReq = (refAt < 0);
    while (!ready) @(negedge clk);
    expAddr = ad;
    expData = d;
    if (w) hostMem[int'(ad)] = d;
    else expRdata = hostMem.exists(int'(ad)) ? hostMem[int'(ad)] : pat(ad);
    @(negedge clk);
    req = 1'b0;
    refReq = 1'b0;
    chk(!ready, "R10 ready low after accept", {31'd0, ready}, 0);
    n = 0;
    while (!(ready && n > refAt)) begin
      @(negedge clk);
      n++;
      refReq = (refAt > 0 && n == refAt);
    end
    refReq = 1'b0;
    chk(actCount == a0 + 1 && rwCount == r0 + 1, "R10 one activate and one column per access",
        actCount - a0 + (rwCount - r0) * 16, 32'h11);
    if (!w) chk(rvCount == v0 + 1, "R4 one rvalid per read", rvCount - v0, 1);
  endtask

  logic [12:0] rowSet [3] = '{13'h0000, 13'h1FFF, 13'h0A5C};
  logic [8:0]  colSet [3] = '{9'h000, 9'h1FF, 9'h0B3};

  initial begin
    int ref0, rwSnap;
    rstN = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; refReq = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(busCmd == C_NOP && !sdDqOe && sdDqm == 4'hF && !rvalid, "R1 reset outputs",
          {22'd0, busCmd, sdDqOe, sdDqm, rvalid}, {22'd0, C_NOP, 1'b0, 4'hF, 1'b0});
    end
    rstN = 1'b1;
    @(negedge clk);
    chk(ready && busCmd == C_NOP, "R1 ready after reset", {27'd0, ready, busCmd}, {27'd0, 1'b1, C_NOP});

    // sweep: every bank with row and column edges, write then read back
    for (int b = 0; b < 4; b++)
      for (int ri = 0; ri < 3; ri++)
        for (int ci = 0; ci < 3; ci++)
          access(1'b1, {b[1:0], rowSet[ri], colSet[ci]}, ~pat({b[1:0], rowSet[ri], colSet[ci]}), 0);
    for (int b = 0; b < 4; b++)
      for (int ri = 0; ri < 3; ri++)
        for (int ci = 0; ci < 3; ci++)
          access(1'b0, {b[1:0], rowSet[ri], colSet[ci]}, 32'h0, 0);

    // never written locations return the model's default contents (R4)
    for (int i = 0; i < 4; i++) access(1'b0, 24'h123456 + 24'(i * 24'h051111), 32'h0, 0);

    // back-to-back write and read of one word, overwrite (R6, R7)
    access(1'b1, 24'hC0FFEE, 32'h01234567, 0);
    access(1'b0, 24'hC0FFEE, 32'h0, 0);
    access(1'b1, 24'hC0FFEE, 32'hFEDCBA98, 0);
    access(1'b0, 24'hC0FFEE, 32'h0, 0);
    chk(refCount == 0, "R9 no refresh without request", refCount, 0);

    // R9: refresh raised in the middle of a read
    ref0 = refCount;
    access(1'b0, 24'h400200, 32'h0, 3);
    rwSnap = lastRwCyc;
    chk(refCount == ref0 + 1 && lastRefCyc > rwSnap, "R9 refresh after access",
        lastRefCyc - rwSnap, 1);
    access(1'b1, 24'h400201, 32'hA5A5F00D, 0);
    chk(lastActCyc > lastRefCyc && refCount == ref0 + 1, "R9 refresh before next activate",
        lastActCyc - lastRefCyc, 1);

    // R9: refresh raised in the middle of a write
    ref0 = refCount;
    access(1'b1, 24'h7FFE00, 32'h5555AAAA, 5);
    chk(refCount == ref0 + 1 && lastRefCyc > lastRwCyc, "R9 refresh after write", refCount - ref0, 1);

    // R9: refresh together with an accepted request
    ref0 = refCount;
    access(1'b0, 24'h7FFE00, 32'h0, -1);
    chk(refCount == ref0 + 1 && lastRefCyc > lastRwCyc, "R9 refresh with request", refCount - ref0, 1);

    // R8: refresh while idle, request queued right behind it
    ref0 = refCount;
    @(negedge clk);
    refReq = 1'b1;
    @(negedge clk);
    refReq = 1'b0;
    access(1'b0, 24'h400201, 32'h0, 0);
    chk(refCount == ref0 + 1 && lastActCyc > lastRefCyc, "R8 idle refresh then access",
        lastActCyc - lastRefCyc, TRFC + 1);

    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule